// File: doc/BRIEF.md
# Flash Write Completion Poller

This engine sits on the host side of a parallel NOR flash and decides when the flash has finished an internal program or erase. The command bytes have already been written by other logic. When the final write strobe of that sequence is done, the host pulses `start_i`. With that pulse it gives the operation type, the target address, the byte being programmed, a read limit and a status method. The engine then reads the target location again and again through a simple request/acknowledge read port, and it judges each returned byte.

Two status methods are supported:

- **Data-complement polling** looks at bit 7.
  - During a program, bit 7 reads as the inverse of bit 7 of the byte being written.
  - During an erase, bit 7 reads as 0.
- **Toggle polling** looks at bit 6. Bit 6 flips on every read while the operation runs, and it stops flipping when the operation ends.

The flash finishes at a moment the host cannot see, so a read taken at that instant can be misleading. A read that looks complete is therefore only a candidate. The engine must read the same location twice more, and both of those reads must also look complete, before it reports success. If either confirming read looks busy, the candidate is rejected and polling resumes. A read limit bounds the whole loop. The engine ends with a one-cycle `done_o` pulse or a one-cycle `timeout_o` pulse.

The state machine has six states:

- **IDLE** waits for `start_i`.
- **POLL** issues ordinary status reads.
- **CONF1** issues the first confirming read.
- **CONF2** issues the second confirming read.
- **DONE** and **TMO** each last one cycle and raise their pulse.

The transitions are:

- IDLE→POLL on a start pulse.
- POLL→CONF1 on a read that looks complete.
- CONF1→CONF2 on a read that looks complete.
- CONF2→DONE on a read that looks complete.
- CONF1/CONF2→POLL on a read that looks busy.
- POLL/CONF1/CONF2→TMO when the read limit is used up.
- DONE→IDLE and TMO→IDLE unconditionally.

Top module: `nor_busy_poller`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `timeout_o` and `busy_o` are all low.
- R2: A `start_i` pulse while idle captures the inputs and raises `busy_o`. `rd_req_o` rises in the next cycle with `rd_addr_o` equal to the captured address. A request stays high until the clock edge where `rd_ack_i` is also high, and that edge completes the read. Only one read is ever in flight.
- R3: In data-complement mode for a program (`op_erase_i`=0, `mode_toggle_i`=0), a read looks complete when its bit 7 equals bit 7 of `data_i`.
- R4: In data-complement mode for an erase (`op_erase_i`=1, `mode_toggle_i`=0), a read looks complete when its bit 7 is 1.
- R5: In toggle mode (`mode_toggle_i`=1, either operation), a read looks complete when its bit 6 equals bit 6 of the previous read of the same run. The first read of a run never looks complete.
- R6: A read that looks complete must be followed by two more reads that both look complete before `done_o` is raised. If either confirming read looks busy, polling resumes.
- R7: Every completed read counts toward the limit `max_polls_i`, and a value of 0 acts as 1. The run ends with `done_o` if the second confirming read lands within the limit. Otherwise it ends with `timeout_o` after exactly the limit's number of reads.
- R8: `done_o` and `timeout_o` are never high together. Each is high for exactly one cycle, in the cycle after the edge that completes the final read. After that cycle the engine is idle, with `busy_o` low and no further requests.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The run continues at its original address with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that starts polling after the final write strobe |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_toggle_i | input | 1 | 1 = toggle polling on bit 6, 0 = data-complement polling on bit 7 |
| addr_i | input | ADDR_W | Location to poll |
| data_i | input | 8 | Byte being programmed |
| max_polls_i | input | CNT_W | Read limit (0 acts as 1) |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data is valid in the same cycle |
| rd_data_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle pulse: completion confirmed |
| timeout_o | output | 1 | One-cycle pulse: read limit used up |
| busy_o | output | 1 | A run is in progress |

## Verification
The timing of each result is fixed:

- The first request is due one cycle after the edge that accepts `start_i`. The bench looks for it at the falling edge that follows.
- `done_o` or `timeout_o` is due in the cycle right after the edge that completes the final read.

The bench's flash model acknowledges at a random delay. At each falling edge it counts the read completed at the preceding rising edge, and it records the cycle of the last completion. It then requires the end pulse to appear at that same falling edge and to be absent at the next one. The expected number of reads and the expected outcome come from bench functions. Those functions use the model's busy length, any injected false-complete read and the limit, and are then checked against the counted reads.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_CONF1,
        ST_CONF2,
        ST_DONE,
        ST_TMO
    } poll_state_e;

    localparam int DATA_W      = 8;
    localparam int POLL_BIT    = 7;
    localparam int TOGGLE_BIT  = 6;

endpackage

// File: rtl/nbp_status_eval.sv
module nbp_status_eval
    import nbp_pkg::*;
(
    input  logic              toggle_mode,
    input  logic              erase_op,
    input  logic              expect_b7,
    input  logic              prev_valid,
    input  logic              prev_b6,
    input  logic [DATA_W-1:0] rd_data,
    output logic              complete
);

    logic unused_low_bits;
    assign unused_low_bits = ^rd_data[TOGGLE_BIT-1:0];

    always_comb begin
        if (toggle_mode) begin
            // R5: stable bit 6 across two consecutive reads
            complete = prev_valid && (rd_data[TOGGLE_BIT] == prev_b6);
        end else if (erase_op) begin
            // R4: erased location shows 1 on bit 7
            complete = rd_data[POLL_BIT];
        end else begin
            // R3: true bit 7 reappears when programming ends
            complete = (rd_data[POLL_BIT] == expect_b7);
        end
    end

endmodule

// File: rtl/nbp_toggle_track.sv
module nbp_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic capture,
    input  logic bit_in,
    output logic prev_valid,
    output logic prev_bit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_bit   <= 1'b0;
        end else if (clear) begin
            prev_valid <= 1'b0;
            prev_bit   <= 1'b0;
        end else if (capture) begin
            prev_valid <= 1'b1;
            prev_bit   <= bit_in;
        end
    end

endmodule

// File: rtl/nbp_poll_count.sv
module nbp_poll_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last_read
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] count_q;
    logic [EXT_W-1:0] eff_limit;
    logic [EXT_W-1:0] count_plus;

    // R7: zero limit behaves as a single read
    assign eff_limit  = (limit == '0) ? EXT_W'(1) : {1'b0, limit};
    assign count_plus = {1'b0, count_q} + EXT_W'(1);
    assign last_read  = (count_plus >= eff_limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_plus[CNT_W-1:0];
        end
    end

    a_r7_count_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, count_q} <= eff_limit) || clear)
        else $error("R7: read counter passed its limit");

endmodule

// File: rtl/nor_busy_poller.sv
module nor_busy_poller
    import nbp_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic              mode_toggle_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic [CNT_W-1:0]  max_polls_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [7:0]        rd_data_i,
    output logic              done_o,
    output logic              timeout_o,
    output logic              busy_o
);

    poll_state_e state_q, state_d;

    logic              erase_q;
    logic              toggle_q;
    logic              exp_b7_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  limit_q;

    logic accept;
    logic reading;
    logic launch;
    logic complete;
    logic last_read;
    logic prev_valid;
    logic prev_b6;
    logic unused_data;

    assign unused_data = ^data_i[6:0];
    assign reading = (state_q == ST_POLL) || (state_q == ST_CONF1) || (state_q == ST_CONF2);
    assign accept  = reading && rd_ack_i;
    assign launch  = (state_q == ST_IDLE) && start_i;

    // capture of run settings, only from idle (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_q  <= 1'b0;
            toggle_q <= 1'b0;
            exp_b7_q <= 1'b0;
            addr_q   <= '0;
            limit_q  <= '0;
        end else if (launch) begin
            erase_q  <= op_erase_i;
            toggle_q <= mode_toggle_i;
            exp_b7_q <= data_i[POLL_BIT];
            addr_q   <= addr_i;
            limit_q  <= max_polls_i;
        end
    end

    nbp_status_eval u_eval (
        .toggle_mode (toggle_q),
        .erase_op    (erase_q),
        .expect_b7   (exp_b7_q),
        .prev_valid  (prev_valid),
        .prev_b6     (prev_b6),
        .rd_data     (rd_data_i),
        .complete    (complete)
    );

    nbp_toggle_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (launch),
        .capture    (accept),
        .bit_in     (rd_data_i[TOGGLE_BIT]),
        .prev_valid (prev_valid),
        .prev_bit   (prev_b6)
    );

    nbp_poll_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .step      (accept),
        .limit     (limit_q),
        .last_read (last_read)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_POLL;
            ST_POLL: begin
                if (rd_ack_i) begin
                    if (last_read)     state_d = ST_TMO;
                    else if (complete) state_d = ST_CONF1;
                end
            end
            ST_CONF1: begin
                if (rd_ack_i) begin
                    if (last_read)     state_d = ST_TMO;
                    else if (complete) state_d = ST_CONF2;
                    else               state_d = ST_POLL;   // R6 rejection
                end
            end
            ST_CONF2: begin
                if (rd_ack_i) begin
                    if (complete)       state_d = ST_DONE;
                    else if (last_read) state_d = ST_TMO;
                    else                state_d = ST_POLL;  // R6 rejection
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_TMO:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rd_req_o  = reading;
        rd_addr_o = addr_q;
        done_o    = (state_q == ST_DONE);
        timeout_o = (state_q == ST_TMO);
        busy_o    = (state_q != ST_IDLE);
    end

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o)
        else $error("R2: request dropped before acknowledge");

    a_r8_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o))
        else $error("R8: done and timeout together");

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |=> (!done_o && !timeout_o && !busy_o && !rd_req_o))
        else $error("R8: end pulse longer than one cycle or engine not idle");

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(rd_addr_o))
        else $error("R9: read address changed during a run");

    a_r6_done_after_conf: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == ST_DONE && state_q != ST_DONE) |-> (state_q == ST_CONF2 && accept))
        else $error("R6: done without second confirming read");

endmodule

// File: tb/nor_busy_poller_tb.sv
`timescale 1ns/1ps
module nor_busy_poller_tb_top;

    localparam int ADDR_W = 21;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              op_erase_i = 1'b0;
    logic              mode_toggle_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [7:0]        data_i = '0;
    logic [CNT_W-1:0]  max_polls_i = '0;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic [7:0]        rd_data_i = '0;
    logic              done_o, timeout_o, busy_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    nor_busy_poller #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .mode_toggle_i(mode_toggle_i), .addr_i(addr_i), .data_i(data_i),
        .max_polls_i(max_polls_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .done_o(done_o),
        .timeout_o(timeout_o), .busy_o(busy_o)
    );

    // flash model settings
    logic              m_erase, m_toggle, m_par;
    int                m_n, m_glitch;
    logic [7:0]        m_exp;
    logic [ADDR_W-1:0] m_addr;

    // observed
    int cyc = 0, reads = 0, last_acc = -1, done_cyc = 0, tmo_cyc = 0;
    int end_at = -1, addr_err = 0, lat = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] flash_byte(input int idx);
        logic [7:0] b;
        bit busy;
        b = 8'($urandom);
        busy = (idx <= m_n) && (idx != m_glitch);
        if (!m_toggle)
            b[7] = m_erase ? !busy : (busy ? ~m_exp[7] : m_exp[7]);
        else
            b[6] = (idx <= m_n) ? (m_par ^ idx[0]) : (m_par ^ m_n[0]);
        return b;
    endfunction

    function automatic int need_reads();
        if (m_toggle) return ((m_n == 0) ? 1 : m_n) + 3;
        return m_n + 3;
    endfunction

    function automatic int eff_limit(input int mx);
        return (mx == 0) ? 1 : mx;
    endfunction

    // flash responder and monitor
    always @(negedge clk) begin
        cyc++;
        if (rd_ack_i) begin
            reads++;
            last_acc = cyc;
            if (rd_addr_o != m_addr) addr_err++;
            rd_ack_i = 1'b0;
            lat = $urandom % 3;
        end
        if (done_o) begin done_cyc++; if (end_at < 0) end_at = cyc; end
        if (timeout_o) begin tmo_cyc++; if (end_at < 0) end_at = cyc; end
        if (rd_req_o) begin
            if (lat == 0) begin
                rd_ack_i = 1'b1;
                rd_data_i = flash_byte(reads + 1);
            end else lat--;
        end
    end

    task automatic run_case(input bit er, input bit tg, input int n, input int mx,
                            input int gl, input bit inject, input string rq);
        int exp_reads;
        bit exp_done;
        m_erase = er; m_toggle = tg; m_n = n; m_glitch = gl;
        m_par = 1'($urandom); m_exp = 8'($urandom);
        m_addr = ADDR_W'($urandom);
        exp_done  = need_reads() <= eff_limit(mx);
        exp_reads = exp_done ? need_reads() : eff_limit(mx);
        @(negedge clk);
        reads = 0; last_acc = -1; done_cyc = 0; tmo_cyc = 0; end_at = -1; addr_err = 0;
        op_erase_i = er; mode_toggle_i = tg; addr_i = m_addr; data_i = m_exp;
        max_polls_i = CNT_W'(mx); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(rd_req_o && busy_o && rd_addr_o == m_addr, "R2 first request", int'(rd_req_o), 1);
        for (int i = 0; i < 4000; i++) begin
            if (done_cyc + tmo_cyc > 0) break;
            if (inject && i == 1) begin
                start_i = 1'b1; addr_i = m_addr ^ ADDR_W'('h1555);
                op_erase_i = ~er; mode_toggle_i = ~tg; max_polls_i = '0;
            end else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        check(done_cyc == (exp_done ? 1 : 0), rq, done_cyc, exp_done ? 1 : 0);
        check(tmo_cyc == (exp_done ? 0 : 1), {rq, " timeout"}, tmo_cyc, exp_done ? 0 : 1);
        check(reads == exp_reads, {rq, " R7 read count"}, reads, exp_reads);
        check(end_at == last_acc, "R8 end pulse timing", end_at, last_acc);
        check(!busy_o && !rd_req_o, "R8 idle after end", int'(busy_o), 0);
        check(addr_err == 0, inject ? "R9 address kept" : "R2 address", addr_err, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!rd_req_o && !done_o && !timeout_o && !busy_o, "R1 reset state", int'(busy_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!rd_req_o && !busy_o, "R1 idle after reset", int'(rd_req_o), 0);

        run_case(0, 0, 5, 50, 0, 0, "R3 program data poll");
        run_case(0, 0, 0, 50, 0, 0, "R3 program already finished");
        run_case(1, 0, 4, 50, 0, 0, "R4 erase data poll");
        run_case(0, 1, 0, 50, 0, 0, "R5 toggle first read");
        run_case(1, 1, 6, 50, 0, 0, "R5 toggle erase");
        run_case(0, 0, 6, 50, 3, 0, "R6 false complete rejected");
        run_case(1, 0, 7, 50, 6, 0, "R6 erase rejection late");
        run_case(0, 0, 5, 8, 0, 0, "R7 limit exactly met");
        run_case(0, 0, 5, 7, 0, 0, "R7 limit one short");
        run_case(1, 1, 3, 0, 0, 0, "R7 zero limit");
        run_case(0, 0, 6, 50, 0, 1, "R9 start while busy");

        for (int k = 0; k < 40; k++) begin
            int n  = $urandom % 12;
            int mx = $urandom % 20;
            int gl = (n >= 2 && ($urandom % 2)) ? 1 + ($urandom % (n - 1)) : 0;
            bit tg = 1'($urandom);
            run_case(1'($urandom), tg, n, mx, tg ? 0 : gl, 0, "R6 R7 random run");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule